// File: doc/BRIEF.md
# Differential Gray Output Encoder

This block sits between a 12-bit converter sample stream and the parallel output pins. It turns each valid sample into an output code. The code is either the sample itself or its difference from an earlier pixel of the same colour, and it is written either in plain binary or in Gray code. Reducing how many output bits toggle at once keeps switching noise out of the image.

In differential mode, the receiver needs absolute values to rebuild the line. The block therefore replaces the difference with the absolute sample at one or two pixel positions, counted from the falling edge of the optical-black pulse. A receiver rebuilds every other pixel by adding each difference to the pixel it was taken against, modulo 4096.

Top module: `dgo_encoder`

## Requirements
- R1: With gray_en_i=0 and diff_en_i=0, code_o equals the sample in plain binary.
- R2: With gray_en_i=1 and ten_bit_i=0, code_o is the 12-bit Gray code of the selected value v, that is v ^ (v >> 1).
- R3: With gray_en_i=1 and ten_bit_i=1, code_o[11:10] equal v[11:10]. code_o[9:0] are the Gray code of v[9:0] alone.
- R4: With diff_en_i=1, a non-standard pixel gives v = (sample − reference) mod 4096. The reference is the previous valid sample when ref_one_i=1, and the valid sample two before when ref_one_i=0. The sample history is zero after reset.
- R5: With diff_en_i=1, a standard pixel carries the absolute sample as v. With ref_one_i=0 the standard pixels are numbers 3+std_phase_i and 4+std_phase_i. With ref_one_i=1 the only standard pixel is number 3+std_phase_i.
- R6: An OB falling edge is a cycle in which ob_i is 0 and ob_i was 1 in the cycle before. A valid sample in that cycle is pixel 1. Each later valid sample takes the next number. Numbering restarts at every falling edge, and before the first edge no pixel is standard.
- R7: code_vld_o rises exactly 1 cycle after a valid input when diff_en_i=0, and exactly 2 cycles after when diff_en_i=1.
- R8: During reset, code_o is 0 and code_vld_o is 0.
- R9: Cycles with smp_vld_i=0 advance neither the pixel numbering nor the sample history.
- R10: Applying Gray decoding and then adding the rebuilt reference to the output stream recovers every input sample exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| smp_i | input | 12 | Converter sample |
| smp_vld_i | input | 1 | Sample valid strobe |
| ob_i | input | 1 | Optical-black pulse, active high |
| gray_en_i | input | 1 | 1 = Gray code output |
| diff_en_i | input | 1 | 1 = differential coding |
| std_phase_i | input | 2 | Offset of the standard pixels |
| ref_one_i | input | 1 | 1 = reference one pixel back and one standard pixel |
| ten_bit_i | input | 1 | 1 = Gray conversion over the low 10 bits only |
| code_o | output | 12 | Output code |
| code_vld_o | output | 1 | Output code valid |

## Verification
The hardest case to reach is a standard pixel that falls on a stretch of the line with gaps in the valid strobe, right after a second OB edge that arrives before numbering has saturated. In that case the numbering and both history slots must all hold across the idle cycles. The stimulus builds lines in which invalid cycles are inserted between samples, and it issues back-to-back OB pulses. It also uses descending and wrapping sample ramps, so that differences cross the modulo boundary. A bench-side decoder then rebuilds each sample from the code stream alone.

// File: rtl/dgo_pkg.sv
package dgo_pkg;
   typedef enum logic {
      REF_TWO_BACK = 1'b0,
      REF_ONE_BACK = 1'b1
   } ref_mode_e;
endpackage

// File: rtl/dgo_pixel_pos.sv
module dgo_pixel_pos #(
   parameter int CNT_W    = 4,
   parameter int STD_BASE = 3
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       vld_i,
   input  logic       ob_i,
   input  logic [1:0] phase_i,
   input  logic       ref_one_i,
   output logic       std_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] BASE    = CNT_W'(STD_BASE);

   initial begin
      assert (32'(STD_BASE) + 5 <= 32'(CNT_MAX))
         else $error("pixel counter too narrow for standard window");
   end

   logic             ob_q;
   logic [CNT_W-1:0] cnt_q;
   logic             fall;
   logic [CNT_W-1:0] idx;
   logic [CNT_W-1:0] first_std;

   assign fall      = ob_q & ~ob_i;
   assign idx       = fall ? CNT_W'(1) : ((cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_W'(1));
   assign first_std = BASE + {{(CNT_W-2){1'b0}}, phase_i};
   assign std_o     = vld_i & ((idx == first_std) |
                      ((ref_one_i == dgo_pkg::REF_TWO_BACK) && (idx == first_std + CNT_W'(1))));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ob_q  <= 1'b0;
         cnt_q <= CNT_MAX;
      end else begin
         ob_q <= ob_i;
         if (fall)
            cnt_q <= vld_i ? CNT_W'(1) : '0;
         else if (vld_i && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   AST_EDGE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ob_q && !ob_i) |=> (cnt_q <= CNT_W'(1))); // R6

   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!vld_i && !(ob_q && !ob_i)) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/dgo_diff.sv
module dgo_diff #(
   parameter int DW = 12
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          vld_i,
   input  logic [DW-1:0] smp_i,
   input  logic          ref_one_i,
   output logic [DW-1:0] diff_o
);
   logic [DW-1:0] h1_q, h2_q;
   logic [DW-1:0] ref_val;

   assign ref_val = ref_one_i ? h1_q : h2_q;
   assign diff_o  = smp_i - ref_val;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         h1_q <= '0;
         h2_q <= '0;
      end else if (vld_i) begin
         h2_q <= h1_q;
         h1_q <= smp_i;
      end
   end

   AST_HIST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !vld_i |=> ($stable(h1_q) && $stable(h2_q))); // R9
endmodule

// File: rtl/dgo_gray.sv
module dgo_gray #(
   parameter int DW     = 12,
   parameter int PART_W = 10
) (
   input  logic [DW-1:0] val_i,
   input  logic          part_i,
   output logic [DW-1:0] gray_o
);
   initial begin
      assert (PART_W > 1 && PART_W < DW) else $error("PART_W out of range");
   end

   logic [DW-1:0] full_g, part_g;

   for (genvar i = 0; i < DW; i++) begin : g_bit
      if (i == DW-1) begin : g_top
         assign full_g[i] = val_i[i];
      end else begin : g_mid
         assign full_g[i] = val_i[i] ^ val_i[i+1];
      end
      if (i >= PART_W-1) begin : g_pass
         assign part_g[i] = val_i[i];
      end else begin : g_low
         assign part_g[i] = val_i[i] ^ val_i[i+1];
      end
   end

   assign gray_o = part_i ? part_g : full_g;
endmodule

// File: rtl/dgo_encoder.sv
module dgo_encoder #(
   parameter int DW       = 12,
   parameter int PART_W   = 10,
   parameter int CNT_W    = 4,
   parameter int STD_BASE = 3
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [DW-1:0] smp_i,
   input  logic          smp_vld_i,
   input  logic          ob_i,
   input  logic          gray_en_i,
   input  logic          diff_en_i,
   input  logic [1:0]    std_phase_i,
   input  logic          ref_one_i,
   input  logic          ten_bit_i,
   output logic [DW-1:0] code_o,
   output logic          code_vld_o
);
   logic          is_std;
   logic [DW-1:0] diff_val, sel_val, gray_val, enc_val;
   logic [DW-1:0] s1_q, s2_q;
   logic          s1_vld_q, s2_vld_q;

   dgo_pixel_pos #(.CNT_W(CNT_W), .STD_BASE(STD_BASE)) u_pos (
      .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(smp_vld_i), .ob_i(ob_i),
      .phase_i(std_phase_i), .ref_one_i(ref_one_i), .std_o(is_std));

   dgo_diff #(.DW(DW)) u_diff (
      .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(smp_vld_i), .smp_i(smp_i),
      .ref_one_i(ref_one_i), .diff_o(diff_val));

   assign sel_val = (diff_en_i && !is_std) ? diff_val : smp_i;

   dgo_gray #(.DW(DW), .PART_W(PART_W)) u_gray (
      .val_i(sel_val), .part_i(ten_bit_i), .gray_o(gray_val));

   assign enc_val = gray_en_i ? gray_val : sel_val;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         s1_q     <= '0;
         s1_vld_q <= 1'b0;
         s2_q     <= '0;
         s2_vld_q <= 1'b0;
      end else begin
         s1_vld_q <= smp_vld_i;
         if (smp_vld_i) s1_q <= enc_val;
         s2_vld_q <= s1_vld_q;
         if (s1_vld_q) s2_q <= s1_q;
      end
   end

   assign code_o     = diff_en_i ? s2_q : s1_q;
   assign code_vld_o = diff_en_i ? s2_vld_q : s1_vld_q;

   AST_PLAIN_BINARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (smp_vld_i && !diff_en_i && !gray_en_i) |=> (code_o == $past(smp_i))); // R1

   AST_FULL_GRAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (smp_vld_i && !diff_en_i && gray_en_i && !ten_bit_i)
      |=> (code_o == $past(smp_i ^ (smp_i >> 1)))); // R2

   AST_TOP_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (smp_vld_i && !diff_en_i && gray_en_i && ten_bit_i)
      |=> (code_o[DW-1:PART_W] == $past(smp_i[DW-1:PART_W]))); // R3

   AST_LAT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (smp_vld_i && !diff_en_i) |=> code_vld_o); // R7

   AST_LAT_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (smp_vld_i && diff_en_i) |=> ##1 code_vld_o); // R7
endmodule

// File: tb/tb_dgo_encoder.sv
module tb_dgo_encoder;
   logic        clk = 1'b0;
   logic        rst_ni = 1'b0;
   logic [11:0] smp = '0;
   logic        vld = 1'b0, ob = 1'b0;
   logic        gray_en = 1'b0, diff_en = 1'b0, ref_one = 1'b0, ten_bit = 1'b0;
   logic [1:0]  phase = '0;
   logic [11:0] code;
   logic        code_vld;

   int n_run = 0, n_fail = 0, cyc = 0;
   bit done = 0;

   logic [11:0] exp_q[$];
   logic [11:0] org_q[$];
   bit          std_q[$];
   int          cyc_q[$];
   string       tag_q[$];

   // bench model state
   bit          m_ob = 0;
   int          m_cnt = 15;
   logic [11:0] m_h1 = '0, m_h2 = '0;
   // bench decoder state
   logic [11:0] r_h1 = '0, r_h2 = '0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dgo_encoder dut (
      .clk_i(clk), .rst_ni(rst_ni), .smp_i(smp), .smp_vld_i(vld), .ob_i(ob),
      .gray_en_i(gray_en), .diff_en_i(diff_en), .std_phase_i(phase),
      .ref_one_i(ref_one), .ten_bit_i(ten_bit), .code_o(code), .code_vld_o(code_vld));

   function automatic logic [11:0] to_gray(logic [11:0] v, bit ten);
      logic [11:0] g = v ^ (v >> 1);
      if (ten) begin
         g[9] = v[9];
         g[11:10] = v[11:10];
      end
      return g;
   endfunction

   function automatic logic [11:0] from_gray(logic [11:0] g, bit ten);
      logic [11:0] b = g;
      int top = ten ? 9 : 11;
      for (int i = top - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   task automatic check(bit ok, string tag, logic [11:0] got, logic [11:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // driver: one cycle of stimulus plus expected-value model
   task automatic drive(logic [11:0] s, bit v, bit o, string extra);
      bit fall;
      int idx, first;
      bit is_std;
      logic [11:0] val, ref_v;
      string tag;
      @(negedge clk);
      smp = s; vld = v; ob = o;
      fall = m_ob && !o;
      idx = fall ? 1 : ((m_cnt == 15) ? 15 : m_cnt + 1);
      first = 3 + int'(phase);
      is_std = v && (idx == first || (!ref_one && idx == first + 1));
      if (v) begin
         ref_v = ref_one ? m_h1 : m_h2;
         val = (diff_en && !is_std) ? s - ref_v : s;
         if (diff_en) tag = is_std ? "R5 R6" : "R4";
         else if (gray_en) tag = ten_bit ? "R3" : "R2";
         else tag = "R1";
         if (gray_en && !ten_bit) tag = {tag, " R2"};
         if (gray_en && ten_bit) tag = {tag, " R3"};
         tag = {tag, extra};
         exp_q.push_back(gray_en ? to_gray(val, ten_bit) : val);
         org_q.push_back(s);
         std_q.push_back(is_std);
         cyc_q.push_back(cyc);
         tag_q.push_back(tag);
         m_h2 = m_h1;
         m_h1 = s;
      end
      if (fall) m_cnt = v ? 1 : 0;
      else if (v && m_cnt != 15) m_cnt++;
      m_ob = o;
   endtask

   // monitor: pops the scoreboard and runs the round-trip decoder
   always @(negedge clk) begin
      if (rst_ni && code_vld) begin
         if (exp_q.size() == 0) begin
            check(0, "R7 unexpected output", code, 12'h000);
         end else begin
            logic [11:0] e, o, dec, rec;
            bit st;
            int c0;
            string t;
            e = exp_q.pop_front(); o = org_q.pop_front(); st = std_q.pop_front();
            c0 = cyc_q.pop_front(); t = tag_q.pop_front();
            check(code === e, t, code, e);
            check((cyc - c0) == (diff_en ? 2 : 1), "R7 latency",
                  12'(cyc - c0), diff_en ? 12'd2 : 12'd1);
            dec = gray_en ? from_gray(code, ten_bit) : code;
            rec = (diff_en && !st) ? dec + (ref_one ? r_h1 : r_h2) : dec;
            check(rec === o, "R10 round trip", rec, o);
            r_h2 = r_h1;
            r_h1 = rec;
         end
      end
   end

   task automatic idle(int n);
      for (int i = 0; i < n; i++) drive(12'h000, 0, 0, "");
   endtask

   // OB pulse then a line of samples; gap>0 inserts invalid cycles
   task automatic line(int n, int start, int step, int gap, string extra);
      drive(12'h000, 0, 1, "");
      drive(12'h000, 0, 1, "");
      for (int i = 0; i < n; i++) begin
         drive(12'(start + i * step), 1, 0, extra);
         if (gap > 0 && (i % 2) == 1)
            for (int k = 0; k < gap; k++) drive(12'h000, 0, 0, "");
      end
      idle(4);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check(code === 12'h000, "R8 reset code", code, 12'h000);
      check(code_vld === 1'b0, "R8 reset valid", {11'b0, code_vld}, 12'h000);
      @(negedge clk);
      rst_ni = 1'b1;

      // plain binary, samples before any OB edge
      for (int i = 0; i < 4; i++) drive(12'(100 + i * 7), 1, 0, " R6");
      idle(3);
      line(10, 12'h123, 37, 0, "");
      // gray 12 bit
      gray_en = 1; line(10, 12'hFF0, 5, 0, "");
      // gray 10 bit
      ten_bit = 1; line(10, 12'hBFE, 3, 0, "");
      // differential, two back, phase 0, binary, wrapping ramp
      gray_en = 0; ten_bit = 0; diff_en = 1; phase = 0; ref_one = 0;
      line(12, 12'h010, -9, 0, "");
      // differential, one back, phase 3, full gray
      gray_en = 1; ref_one = 1; phase = 3;
      line(12, 12'hFF8, 3, 0, "");
      // differential, two back, phase 2, ten-bit gray, gaps, R9
      ten_bit = 1; ref_one = 0; phase = 2;
      line(12, 12'h7F0, 77, 2, " R9");
      // back-to-back OB pulses before saturation, R6
      ten_bit = 0; phase = 1;
      line(3, 12'h300, 40, 0, " R6");
      line(9, 12'h050, -300, 1, " R6 R9");
      // one back, phase 0, binary
      gray_en = 0; ref_one = 1; phase = 0;
      line(8, 12'h800, 1000, 0, "");
      idle(4);
      diff_en = 0;
      idle(4);
      check(exp_q.size() == 0, "R7 drained", 12'(exp_q.size()), 12'h000);
      done = 1;
   end

   initial begin
      repeat (100000) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) check(0, "watchdog", 12'h000, 12'h001);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule